// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block builds the word a flash device puts on its data pins while a program or erase runs inside the array, while an erase is suspended, or after an operation has aborted. The command and erase sequencers supply the operation state: a busy flag, the kind of operation, the address of the suspended erase region, a write-buffer abort flag, a pulse for an aborted attempt on a protected target, and the last datum written. The read address and the chip-enable and output-enable strobes come from the host bus. From these inputs the block drives a polling bit, two toggle bits, an abort bit and an open-drain ready/busy pull-down. When no operation, abort or hold is active, array data passes through unchanged.

The two toggle bits do not follow the system clock. Each one flips only on the start of a read access. This lets host software tell an active program, an active erase and a suspended region apart by reading the same location twice. After an attempt on a protected target, the status bits stay up for a set number of cycles. The operation kind seen at the moment of the abort is used for that whole window.

Top module: `flash_status_gen`

## Requirements
- R1: With no operation busy, no abort hold, no write-buffer abort, and the read address outside any suspended region, `dq` equals `array_data`, `rb_pull_low` is 0, and `dq_oe` is 1 exactly when `ce_n` and `oe_n` are both 0.
- R2: While `op_busy` is 1 and the kind is a program (`op_kind` 0 = word program, 1 = buffer program), bit 7 of `dq` is the inverse of bit 7 of `last_datum`. Every bit other than 7, 6, 2 and 1 reads 0.
- R3: While `op_busy` is 1 and the kind is an erase (`op_kind` 2 or 3, so `op_kind[1]` = 1), bit 7 of `dq` reads 0.
- R4: Bit 6 of `dq` flips once at the start of each read access while any status source is active (busy, abort hold or write-buffer abort). A read access starts in the first cycle in which both `ce_n` and `oe_n` are 0. Bit 6 does not change while a read is held, and it reads 1 on the first such read after reset.
- R5: Bit 2 of `dq` flips at each read start during an erase status. It keeps its value during a program status.
- R6: While `susp_active` is 1 and no status source is active, a read whose `rd_addr[ADDR_W-1:REGION_LSB]` equals `susp_addr[ADDR_W-1:REGION_LSB]` returns bit 7 = 1, bit 6 = 1, bit 2 flipping per read, and all other bits 0, with `rb_pull_low` = 0. A read outside that region returns `array_data`.
- R7: A program that is busy during erase suspend gives program status on every address. Bit 6 toggles and `rb_pull_low` is 1.
- R8: `rb_pull_low` is 1 exactly while `op_busy`, the abort hold, or `wb_abort` is active.
- R9: A one-cycle `prot_abort` pulse keeps status active for HOLD_CYC clock cycles after the edge that samples it. The `op_kind` value of that edge is used throughout the window. When the window ends, array reads return.
- R10: Bit 1 of `dq` is 1 exactly when status is shown and `wb_abort` is 1. A write-buffer abort alone gives program-style status: bit 7 is the inverse of `last_datum[7]`.
- R11: Reset clears both toggle bits and any abort hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_busy | input | 1 | An internal program or erase is running |
| op_kind | input | 2 | 0 word program, 1 buffer program, 2/3 erase |
| susp_active | input | 1 | An erase is suspended |
| susp_addr | input | ADDR_W | Address inside the suspended region |
| wb_abort | input | 1 | A write-buffer operation has aborted |
| prot_abort | input | 1 | Pulse: an attempt on a protected target aborted |
| last_datum | input | DATA_W | Last word written or loaded |
| rd_addr | input | ADDR_W | Read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data | input | DATA_W | Word read from the array |
| dq | output | DATA_W | Data or status word |
| dq_oe | output | 1 | Data pins driven |
| rb_pull_low | output | 1 | Pull the open-drain ready/busy line low |

## Verification
The bench sweeps every operation kind against both values of the datum's bit 7 and both states of the write-buffer abort. It reads three times per combination, which separates program-style polling from erase polling and shows that bit 2 toggles only in erase status. The bench then repeats reads in suspend mode, both inside and outside the region and with a program running. This separates suspended-region status from pass-through and from program status. An abort pulse is sent with its kind changed right after, to show that the sampled kind is held, and a separate pulse is counted cycle by cycle to find the exact end of the hold. One held-low read shows that a toggle moves once per access, not once per clock.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
   typedef enum logic [1:0] {
      OPK_WORD  = 2'd0,
      OPK_BUF   = 2'd1,
      OPK_ERASE = 2'd2,
      OPK_ERX   = 2'd3
   } op_kind_e;

   function automatic logic kind_is_erase(input logic [1:0] k);
      return k[1];
   endfunction
endpackage

// File: rtl/fsg_read_edge.sv
module fsg_read_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   output logic rd_on,
   output logic rd_start
);
   logic prev_q;

   assign rd_on    = ~ce_n & ~oe_n;
   assign rd_start = rd_on & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= rd_on;
   end

   assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> !rd_start);
endmodule

// File: rtl/fsg_abort_hold.sv
module fsg_abort_hold #(
   parameter int HOLD_CYC = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       prot_abort,
   input  logic [1:0] op_kind,
   output logic       hold_act,
   output logic [1:0] hold_kind
);
   generate
      if (HOLD_CYC == 0) begin : g_nohold
         assign hold_act  = 1'b0;
         assign hold_kind = 2'd0;
      end else begin : g_hold
         localparam int CW = $clog2(HOLD_CYC + 1);
         localparam logic [CW-1:0] LOADV = CW'(HOLD_CYC);
         logic [CW-1:0] cnt_q;
         logic [1:0]    kind_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               kind_q <= 2'd0;
            end else if (prot_abort) begin
               cnt_q  <= LOADV;
               kind_q <= op_kind;
            end else if (cnt_q != '0) begin
               cnt_q  <= cnt_q - 1'b1;
            end
         end

         assign hold_act  = (cnt_q != '0);
         assign hold_kind = kind_q;

         assert_hold_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
            prot_abort |=> hold_act);
         assert_kind_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_act && !prot_abort) |=> $stable(hold_kind));
      end
   endgenerate
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_start,
   input  logic adv6,
   input  logic adv2,
   output logic t6,
   output logic t2
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t6 <= 1'b0;
         t2 <= 1'b0;
      end else if (rd_start) begin
         if (adv6) t6 <= ~t6;
         if (adv2) t2 <= ~t2;
      end
   end

   assert_t6_only_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_start |=> $stable(t6));
   assert_t2_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && !adv2) |=> $stable(t2));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 12,
   parameter int REGION_LSB = 8,
   parameter int HOLD_CYC   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_busy,
   input  logic [1:0]        op_kind,
   input  logic              susp_active,
   input  logic [ADDR_W-1:0] susp_addr,
   input  logic              wb_abort,
   input  logic              prot_abort,
   input  logic [DATA_W-1:0] last_datum,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] dq,
   output logic              dq_oe,
   output logic              rb_pull_low
);
   import flash_stat_pkg::*;

   localparam int BIT_POLL = 7;
   localparam int BIT_TGL  = 6;
   localparam int BIT_TGL2 = 2;
   localparam int BIT_ABT  = 1;

   initial begin
      assert_width_ok: assert (DATA_W >= 8);
      assert_region_ok: assert (REGION_LSB >= 0 && REGION_LSB < ADDR_W);
   end

   logic       rd_on, rd_start, hold_act;
   logic [1:0] hold_kind;
   logic       t6, t2;
   logic       stat_act, eff_erase, in_region, susp_rd, adv6, adv2;
   logic [DATA_W-1:0] stat_word;

   fsg_read_edge u_edge (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
      .rd_on(rd_on), .rd_start(rd_start)
   );

   fsg_abort_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .prot_abort(prot_abort), .op_kind(op_kind),
      .hold_act(hold_act), .hold_kind(hold_kind)
   );

   assign in_region = (rd_addr[ADDR_W-1:REGION_LSB] == susp_addr[ADDR_W-1:REGION_LSB]);

   always_comb begin
      stat_act  = op_busy | hold_act | wb_abort;
      if (op_busy)       eff_erase = kind_is_erase(op_kind);
      else if (hold_act) eff_erase = kind_is_erase(hold_kind);
      else               eff_erase = 1'b0;
      susp_rd   = ~stat_act & susp_active & in_region;
      adv6      = stat_act;
      adv2      = (stat_act & eff_erase) | susp_rd;
   end

   fsg_toggle u_tgl (
      .clk(clk), .rst_n(rst_n), .rd_start(rd_start),
      .adv6(adv6), .adv2(adv2), .t6(t6), .t2(t2)
   );

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_sbit
         if (i == BIT_POLL) begin : g_poll
            assign stat_word[i] = stat_act ? (~eff_erase & ~last_datum[BIT_POLL]) : 1'b1;
         end else if (i == BIT_TGL) begin : g_t6
            assign stat_word[i] = stat_act ? t6 : 1'b1;
         end else if (i == BIT_TGL2) begin : g_t2
            assign stat_word[i] = t2;
         end else if (i == BIT_ABT) begin : g_abt
            assign stat_word[i] = stat_act & wb_abort;
         end else begin : g_zero
            assign stat_word[i] = 1'b0;
         end
      end
   endgenerate

   assign dq          = (stat_act | susp_rd) ? stat_word : array_data;
   assign dq_oe       = rd_on;
   assign rb_pull_low = stat_act;

   assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rb_pull_low && !susp_active) |-> (dq == array_data));
   assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_busy && op_kind[1]) |-> (dq[BIT_POLL] == 1'b0));
   assert_busy_pulls_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_busy || wb_abort) |-> rb_pull_low);
   assert_abt_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_pull_low && !wb_abort) |-> (dq[BIT_ABT] == 1'b0));
endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
   localparam int DW = 16, AW = 12, RL = 8, HC = 20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic op_busy = 0, susp_active = 0, wb_abort = 0, prot_abort = 0, ce_n = 1, oe_n = 1;
   logic [1:0] op_kind = 0;
   logic [AW-1:0] susp_addr = 0, rd_addr = 0;
   logic [DW-1:0] last_datum = 0, array_data = 0;
   logic [DW-1:0] dq;
   logic dq_oe, rb_pull_low;

   int total = 0, bad = 0;
   logic m_t6 = 0, m_t2 = 0, b_hold = 0;
   logic [1:0] b_hkind = 0;

   always #5 clk = ~clk;

   flash_status_gen #(.DATA_W(DW), .ADDR_W(AW), .REGION_LSB(RL), .HOLD_CYC(HC)) u0 (
      .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_kind(op_kind),
      .susp_active(susp_active), .susp_addr(susp_addr), .wb_abort(wb_abort),
      .prot_abort(prot_abort), .last_datum(last_datum), .rd_addr(rd_addr),
      .ce_n(ce_n), .oe_n(oe_n), .array_data(array_data),
      .dq(dq), .dq_oe(dq_oe), .rb_pull_low(rb_pull_low)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic b_stat();
      return op_busy | b_hold | wb_abort;
   endfunction

   function automatic logic b_erase();
      if (op_busy) return op_kind[1];
      if (b_hold)  return b_hkind[1];
      return 1'b0;
   endfunction

   function automatic logic b_susp_rd(input logic [AW-1:0] a);
      return !b_stat() && susp_active && (a[AW-1:RL] == susp_addr[AW-1:RL]);
   endfunction

   function automatic logic [DW-1:0] exp_dq(input logic [AW-1:0] a);
      logic [DW-1:0] w = '0;
      if (b_stat()) begin
         w[7] = b_erase() ? 1'b0 : ~last_datum[7];
         w[6] = m_t6;
         w[2] = m_t2;
         w[1] = wb_abort;
         return w;
      end
      if (b_susp_rd(a)) begin
         w[7] = 1'b1; w[6] = 1'b1; w[2] = m_t2;
         return w;
      end
      return array_data;
   endfunction

   task automatic rd(input string req, input logic [AW-1:0] a);
      @(negedge clk);
      rd_addr = a; ce_n = 0; oe_n = 0;
      if (b_stat()) m_t6 = ~m_t6;
      if ((b_stat() && b_erase()) || b_susp_rd(a)) m_t2 = ~m_t2;
      @(negedge clk);
      chk(req, dq, exp_dq(a));
      chk({req, " oe"}, {15'd0, dq_oe}, 16'd1);
      chk({req, " rb"}, {15'd0, rb_pull_low}, {15'd0, b_stat()});
      ce_n = 1; oe_n = 1;
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      array_data = 16'h5A3C; last_datum = 16'h0080;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 reset rb", {15'd0, rb_pull_low}, 16'd0);
      chk("R11 reset oe", {15'd0, dq_oe}, 16'd0);
      rst_n = 1;
      // R1: idle pass-through with varied data
      for (int i = 0; i < 6; i++) begin
         @(negedge clk) array_data = 16'h1111 * i[15:0] ^ 16'h8421;
         rd("R1 idle pass", AW'(i * 37));
      end
      @(negedge clk);
      chk("R1 oe off", {15'd0, dq_oe}, 16'd0);
      // R2 R3 R4 R5 R10 sweep
      for (int k = 0; k < 4; k++)
         for (int b = 0; b < 2; b++)
            for (int ab = 0; ab < 2; ab++) begin
               @(negedge clk);
               op_busy = 1; op_kind = k[1:0]; last_datum = b[0] ? 16'hFF80 : 16'h007F;
               wb_abort = ab[0];
               for (int r = 0; r < 3; r++)
                  rd(k[1] ? "R3 R5 erase status" : "R2 R5 R10 program status", AW'(r));
            end
      @(negedge clk) op_busy = 0;
      // R10: write-buffer abort alone
      wb_abort = 1; last_datum = 16'h0000;
      for (int r = 0; r < 2; r++) rd("R10 abort alone", AW'(r));
      @(negedge clk) wb_abort = 0;
      // R4: held read advances once only
      @(negedge clk) op_busy = 1; op_kind = 2'd0;
      rd_addr = 0; ce_n = 0; oe_n = 0; m_t6 = ~m_t6;
      repeat (5) @(negedge clk);
      chk("R4 held read", {15'd0, dq[6]}, {15'd0, m_t6});
      ce_n = 1; oe_n = 1;
      @(negedge clk) op_busy = 0;
      // R6: suspend region reads in and out
      susp_active = 1; susp_addr = 12'h3A0; array_data = 16'hC3C3;
      for (int r = 0; r < 4; r++) rd("R6 suspended region", 12'h300 | AW'(r * 5));
      for (int r = 0; r < 3; r++) rd("R6 outside region", 12'h500 | AW'(r));
      // R7: program during suspend
      @(negedge clk) op_busy = 1; op_kind = 2'd1; last_datum = 16'h0000;
      for (int r = 0; r < 3; r++) rd("R7 program in suspend", (r == 0) ? 12'h310 : 12'h710);
      @(negedge clk) op_busy = 0; susp_active = 0;
      // R9: abort hold keeps sampled kind
      @(negedge clk) op_kind = 2'd2; prot_abort = 1;
      @(negedge clk) prot_abort = 0; op_kind = 2'd0; b_hold = 1; b_hkind = 2'd2;
      for (int r = 0; r < 3; r++) rd("R9 hold erase status", AW'(r));
      repeat (HC) @(negedge clk);
      b_hold = 0;
      rd("R9 hold over", 12'h001);
      // R8 R9: exact window length
      @(negedge clk) prot_abort = 1;
      @(negedge clk) prot_abort = 0;
      repeat (HC - 1) @(posedge clk);
      @(negedge clk);
      chk("R8 R9 last hold cycle", {15'd0, rb_pull_low}, 16'd1);
      @(negedge clk);
      chk("R8 R9 hold ended", {15'd0, rb_pull_low}, 16'd0);
      chk("R9 array back", dq, array_data);
      // R11: reset clears toggles
      @(negedge clk) rst_n = 0; m_t6 = 0; m_t2 = 0;
      @(negedge clk) rst_n = 1; op_busy = 1; op_kind = 2'd3;
      rd("R11 toggles after reset", 12'h0);
      chk("R11 t6 first read", {15'd0, dq[6]}, 16'd1);
      @(negedge clk) op_busy = 0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule